// File: doc/BRIEF.md
# Quadrature Tuning Dial Frequency Accumulator

This block turns the two pulse trains from an optical tuning dial into changes of a channel frequency. The two sensor lines carry square waves a quarter period apart. The block first synchronises both lines to the system clock. It decodes each legal change of the sensor pair into one step up or one step down. It then gathers those steps in a small window counter. A periodic clear strobe empties the window counter. A separate read strobe takes a snapshot of the window, publishes it on the status outputs, and adds the count to the frequency register or subtracts it.

The frequency is held as an integer in units of 10 kHz. It loads 14500 (145.00 MHz) on reset and stays within 14400 to 14600. A source-select input marks a read as a memory-path request. Such a read is reported in the status, but it leaves the frequency alone. Steps are never applied one by one. Each read applies the whole window at once as a single signed change.

Top module: `dial_tuner`

## Requirements
- R1: While reset is low at a clock edge, and after it, freq_code reads 14500, stat_cnt reads 0, stat_up reads 1 and stat_mem reads 0.
- R2: Taking {dial_a, dial_b} as a 2-bit code, the moves 00→01→11→10→00 are steps up and the reverse moves are steps down. Each move that changes exactly one input adds one step to the window.
- R3: A move that changes both sensor inputs between two synchronised samples is not counted and leaves the window unchanged.
- R4: The window count saturates at 3. Further steps in the same direction keep it at 3.
- R5: A step opposite to the window's direction restarts the window at a count of 1 in the new direction.
- R6: A high win_clr empties the window. A step decoded in the same cycle as the clear becomes the first step of the new window.
- R7: stat_cnt, stat_up and stat_mem load the window count, the window direction and src_mem at the clock edge where poll_rd is high. At every other edge they hold their value.
- R8: A read with src_mem low changes freq_code by +count (stat_up=1) or -count (stat_up=0), visible in the cycle after the read. Without a read, freq_code holds.
- R9: freq_code never leaves 14400..14600. A change that would cross a band edge stops at that edge.
- R10: A read with src_mem high sets stat_mem to 1 and leaves freq_code unchanged.
- R11: When poll_rd and win_clr are high in the same cycle, the read uses the count from before the clear, and the window is empty afterwards.
- R12: A read does not consume the window. A second read with no clear in between applies the same count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dial_a | input | 1 | Sensor line A, asynchronous |
| dial_b | input | 1 | Sensor line B, asynchronous |
| win_clr | input | 1 | Periodic window clear strobe |
| poll_rd | input | 1 | Read strobe: snapshot window and apply it |
| src_mem | input | 1 | 1 = request comes from the memory path |
| freq_code | output | 15 | Frequency in units of 10 kHz |
| stat_cnt | output | 2 | Window count captured at the last read |
| stat_up | output | 1 | Direction captured at the last read (1 = up) |
| stat_mem | output | 1 | Source captured at the last read (1 = memory) |

## Verification
A read strobe and a clear strobe can fall in the same cycle. So can a clear strobe and a decoded dial step. The bench raises poll_rd and win_clr together after building a known window. It then checks that the frequency moved by the old count and that a following read reports zero. To hit a step in the clear cycle, the bench changes a sensor line and times the clear for the cycle in which the synchronised change reaches the decoder. It then checks that the next read reports a count of one in that step's direction.

// File: rtl/dial_pkg.sv
// Package: shared types and constants for the tuning dial accumulator.
// Assumes: the window count width is fixed for the whole block.
package dial_pkg;
    // Width of the per-window step count
    localparam int STEP_CNT_W = 2;

    // Direction of a step or of a window
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dial_dir_e;

    // Snapshot published at each read strobe
    typedef struct packed {
        logic [STEP_CNT_W-1:0] cnt;
        dial_dir_e             dir;
        logic                  mem;
    } dial_status_t;
endpackage

// File: rtl/dial_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each input is a slow level signal, so bits may be sampled
// independently; reset drives every stage to zero.
module dial_sync #(
    parameter int CHANNELS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] async_in,
    output logic [CHANNELS-1:0] sync_out
);
    genvar ch;
    generate
        for (ch = 0; ch < CHANNELS; ch++) begin : g_chan
            logic [STAGES-1:0] chain_q;

            // Shift the raw input through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in[ch]};
            end

            assign sync_out[ch] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dial_quad_decode.sv
// Module: turns the synchronised sensor pair into single-cycle step pulses.
// Assumes: code = {a, b}; up order 00->01->11->10->00; a change of both
// bits at once is illegal and dropped.
module dial_quad_decode
    import dial_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_sync,
    input  logic      b_sync,
    output logic      step_vld,
    output dial_dir_e step_dir
);
    logic [1:0] cur_code;
    logic [1:0] prev_q;
    logic       is_up;
    logic       is_dn;

    assign cur_code = {a_sync, b_sync};

    // Remember the last sampled code
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= cur_code;
    end

    // Match the current code against the two legal neighbours of the previous one
    always_comb begin
        is_up    = (cur_code == {prev_q[0], ~prev_q[1]});
        is_dn    = (cur_code == {~prev_q[0], prev_q[1]});
        step_vld = is_up | is_dn;
        step_dir = is_up ? DIR_UP : DIR_DOWN;
    end

    // R3
    double_move_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == ~prev_q) |-> !step_vld);
endmodule

// File: rtl/dial_step_window.sv
// Module: gathers decoded steps into a saturating count for one poll window.
// Assumes: a clear empties the window, and a step in the clear cycle opens
// the new window; a reversal restarts the count at one.
module dial_step_window
    import dial_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_vld,
    input  dial_dir_e             step_dir,
    input  logic                  win_clr,
    output logic [STEP_CNT_W-1:0] cnt_q,
    output dial_dir_e             dir_q
);
    localparam logic [STEP_CNT_W-1:0] CNT_MAX = {STEP_CNT_W{1'b1}};

    logic [STEP_CNT_W-1:0] cnt_n;
    dial_dir_e             dir_n;

    // Work out the next window count and direction
    always_comb begin
        cnt_n = cnt_q;
        dir_n = dir_q;
        if (win_clr) begin
            cnt_n = step_vld ? STEP_CNT_W'(1) : '0;
            if (step_vld) dir_n = step_dir;
        end else if (step_vld) begin
            if (step_dir != dir_q || cnt_q == '0) begin
                cnt_n = STEP_CNT_W'(1);
                dir_n = step_dir;
            end else if (cnt_q != CNT_MAX) begin
                cnt_n = cnt_q + STEP_CNT_W'(1);
            end
        end
    end

    // Hold the window state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_n;
            dir_q <= dir_n;
        end
    end

    // R4
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && step_vld && step_dir == dir_q && !win_clr) |=> (cnt_q == CNT_MAX));
    // R5
    reversal_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_dir != dir_q && !win_clr) |=> (cnt_q == STEP_CNT_W'(1)));
    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_clr && !step_vld) |=> (cnt_q == '0));
endmodule

// File: rtl/dial_freq_accum.sv
// Module: frequency register updated by one signed window count per read.
// Assumes: units of 10 kHz; the result is clamped to [F_MIN, F_MAX];
// memory-path reads do not step the frequency.
module dial_freq_accum
    import dial_pkg::*;
#(
    parameter int FREQ_W   = 15,
    parameter int F_PRESET = 14500,
    parameter int F_MIN    = 14400,
    parameter int F_MAX    = 14600
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic                  src_mem,
    input  logic [STEP_CNT_W-1:0] cnt,
    input  dial_dir_e             dir,
    output logic [FREQ_W-1:0]     freq_q
);
    localparam logic [FREQ_W:0] LIM_LO = (FREQ_W+1)'(F_MIN);
    localparam logic [FREQ_W:0] LIM_HI = (FREQ_W+1)'(F_MAX);

    logic [FREQ_W:0]   wide_cur;
    logic [FREQ_W:0]   wide_cnt;
    logic [FREQ_W:0]   sum_up;
    logic [FREQ_W-1:0] freq_n;

    // Compute the clamped result of applying the window
    always_comb begin
        wide_cur = {1'b0, freq_q};
        wide_cnt = (FREQ_W+1)'(cnt);
        sum_up   = wide_cur + wide_cnt;
        if (dir == DIR_UP)
            freq_n = (sum_up > LIM_HI) ? FREQ_W'(F_MAX) : sum_up[FREQ_W-1:0];
        else
            freq_n = (wide_cur < LIM_LO + wide_cnt) ? FREQ_W'(F_MIN)
                                                    : FREQ_W'(wide_cur - wide_cnt);
    end

    // Load the preset on reset, apply the window on a dial read
    always_ff @(posedge clk) begin
        if (!rst_n)              freq_q <= FREQ_W'(F_PRESET);
        else if (rd && !src_mem) freq_q <= freq_n;
    end

    // R8
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(freq_q));
    // R8
    freq_up_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !src_mem && dir == DIR_UP) |=> (freq_q >= $past(freq_q)));
    // R9
    band_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_q >= FREQ_W'(F_MIN)) && (freq_q <= FREQ_W'(F_MAX)));
    // R10
    mem_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && src_mem) |=> $stable(freq_q));
endmodule

// File: rtl/dial_tuner.sv
// Module: top of the tuning dial accumulator. It chains the synchroniser,
// the quadrature decoder, the step window and the frequency register,
// and latches the status snapshot on each read.
// Assumes: win_clr, poll_rd and src_mem are synchronous to clk.
module dial_tuner
    import dial_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FREQ_W      = 15,
    parameter int F_PRESET    = 14500,
    parameter int F_MIN       = 14400,
    parameter int F_MAX       = 14600
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dial_a,
    input  logic                  dial_b,
    input  logic                  win_clr,
    input  logic                  poll_rd,
    input  logic                  src_mem,
    output logic [FREQ_W-1:0]     freq_code,
    output logic [STEP_CNT_W-1:0] stat_cnt,
    output logic                  stat_up,
    output logic                  stat_mem
);
    logic [1:0]            sens_sync;
    logic                  step_vld;
    dial_dir_e             step_dir;
    logic [STEP_CNT_W-1:0] win_cnt;
    dial_dir_e             win_dir;
    dial_status_t          stat_q;

    dial_sync #(.CHANNELS(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dial_a, dial_b}),
        .sync_out (sens_sync)
    );

    dial_quad_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_sync   (sens_sync[1]),
        .b_sync   (sens_sync[0]),
        .step_vld (step_vld),
        .step_dir (step_dir)
    );

    dial_step_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_vld (step_vld),
        .step_dir (step_dir),
        .win_clr  (win_clr),
        .cnt_q    (win_cnt),
        .dir_q    (win_dir)
    );

    dial_freq_accum #(
        .FREQ_W   (FREQ_W),
        .F_PRESET (F_PRESET),
        .F_MIN    (F_MIN),
        .F_MAX    (F_MAX)
    ) u_freq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (poll_rd),
        .src_mem (src_mem),
        .cnt     (win_cnt),
        .dir     (win_dir),
        .freq_q  (freq_code)
    );

    // Capture the window snapshot only at a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '{cnt: '0, dir: DIR_UP, mem: 1'b0};
        else if (poll_rd) stat_q <= '{cnt: win_cnt, dir: win_dir, mem: src_mem};
    end

    assign stat_cnt = stat_q.cnt;
    assign stat_up  = (stat_q.dir == DIR_UP);
    assign stat_mem = stat_q.mem;

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_rd |=> ($stable(stat_cnt) && $stable(stat_up) && $stable(stat_mem)));
    // R10
    mem_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && src_mem) |=> stat_mem);
endmodule

// File: tb/dial_tuner_tb.sv
// Bench: directed scenarios for dial_tuner. Each task drives one scenario
// and checks its own results. Inputs change on the falling edge and
// outputs are sampled on the falling edge.
module dial_tuner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dial_a = 1'b0;
    logic        dial_b = 1'b0;
    logic        win_clr = 1'b0;
    logic        poll_rd = 1'b0;
    logic        src_mem = 1'b0;
    logic [14:0] freq_code;
    logic [1:0]  stat_cnt;
    logic        stat_up;
    logic        stat_mem;

    int n_chk = 0;
    int n_fail = 0;
    int exp_freq = 14500;
    logic [1:0] ab = 2'b00;

    always #2 clk = ~clk;

    dial_tuner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dial_a    (dial_a),
        .dial_b    (dial_b),
        .win_clr   (win_clr),
        .poll_rd   (poll_rd),
        .src_mem   (src_mem),
        .freq_code (freq_code),
        .stat_cnt  (stat_cnt),
        .stat_up   (stat_up),
        .stat_mem  (stat_mem)
    );

    // Compare one value and count the result
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Move the sensor pair one legal step and let it settle
    task automatic move(input bit up);
        @(negedge clk);
        ab = up ? {ab[0], ~ab[1]} : {~ab[0], ab[1]};
        {dial_a, dial_b} = ab;
        repeat (4) @(negedge clk);
    endtask

    // One-cycle strobe on win_clr
    task automatic clear_win();
        @(negedge clk); win_clr = 1'b1;
        @(negedge clk); win_clr = 1'b0;
        @(negedge clk);
    endtask

    // One-cycle read strobe, then sample the outputs
    task automatic do_read(input bit mem);
        @(negedge clk); poll_rd = 1'b1; src_mem = mem;
        @(negedge clk); poll_rd = 1'b0; src_mem = 1'b0;
    endtask

    // Apply a dial read to the model frequency with clamping
    function automatic int model_apply(input int f, input int c, input bit up);
        int r;
        r = up ? f + c : f - c;
        if (r > 14600) r = 14600;
        if (r < 14400) r = 14400;
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "freq", freq_code, 14500);
        chk("R1", "cnt", stat_cnt, 0);
        chk("R1", "up", stat_up, 1);
        chk("R1", "mem", stat_mem, 0);
    endtask

    task automatic t_up_two();
        clear_win();
        move(1); move(1);
        do_read(0);
        exp_freq = model_apply(exp_freq, 2, 1);
        chk("R2", "cnt after two up", stat_cnt, 2);
        chk("R2", "dir up", stat_up, 1);
        chk("R8", "freq +2", freq_code, exp_freq);
    endtask

    task automatic t_down_one();
        clear_win();
        move(0);
        do_read(0);
        exp_freq = model_apply(exp_freq, 1, 0);
        chk("R2", "cnt one down", stat_cnt, 1);
        chk("R2", "dir down", stat_up, 0);
        chk("R8", "freq -1", freq_code, exp_freq);
    endtask

    task automatic t_saturate();
        clear_win();
        for (int i = 0; i < 5; i++) move(1);
        do_read(0);
        exp_freq = model_apply(exp_freq, 3, 1);
        chk("R4", "saturated cnt", stat_cnt, 3);
        chk("R4", "freq +3", freq_code, exp_freq);
    endtask

    task automatic t_double_move();
        clear_win();
        @(negedge clk);
        ab = ~ab;
        {dial_a, dial_b} = ab;
        repeat (5) @(negedge clk);
        do_read(0);
        chk("R3", "illegal move cnt", stat_cnt, 0);
        chk("R3", "freq unchanged", freq_code, exp_freq);
    endtask

    task automatic t_reverse();
        clear_win();
        move(1); move(1); move(0);
        do_read(0);
        exp_freq = model_apply(exp_freq, 1, 0);
        chk("R5", "reversal cnt", stat_cnt, 1);
        chk("R5", "reversal dir", stat_up, 0);
        chk("R5", "freq", freq_code, exp_freq);
    endtask

    task automatic t_status_hold();
        clear_win();
        move(1);
        do_read(0);
        exp_freq = model_apply(exp_freq, 1, 1);
        move(0); move(0);
        repeat (3) @(negedge clk);
        chk("R7", "cnt held", stat_cnt, 1);
        chk("R7", "dir held", stat_up, 1);
        chk("R8", "freq held", freq_code, exp_freq);
    endtask

    task automatic t_reread();
        clear_win();
        move(1); move(1);
        do_read(0);
        do_read(0);
        exp_freq = model_apply(model_apply(exp_freq, 2, 1), 2, 1);
        chk("R12", "double apply", freq_code, exp_freq);
        chk("R12", "cnt still 2", stat_cnt, 2);
    endtask

    task automatic t_memory();
        clear_win();
        move(1); move(1); move(1);
        do_read(1);
        chk("R10", "mem flag", stat_mem, 1);
        chk("R10", "cnt reported", stat_cnt, 3);
        chk("R10", "freq unchanged", freq_code, exp_freq);
        do_read(0);
        exp_freq = model_apply(exp_freq, 3, 1);
        chk("R10", "mem flag cleared", stat_mem, 0);
    endtask

    task automatic t_read_clear();
        clear_win();
        move(0); move(0);
        @(negedge clk); poll_rd = 1'b1; win_clr = 1'b1;
        @(negedge clk); poll_rd = 1'b0; win_clr = 1'b0;
        exp_freq = model_apply(exp_freq, 2, 0);
        chk("R11", "pre-clear cnt", stat_cnt, 2);
        chk("R11", "freq -2", freq_code, exp_freq);
        do_read(0);
        chk("R11", "window empty", stat_cnt, 0);
        chk("R11", "freq after empty read", freq_code, exp_freq);
    endtask

    task automatic t_step_in_clear();
        clear_win();
        move(1); move(1); move(1);
        @(negedge clk);
        ab = {~ab[0], ab[1]};
        {dial_a, dial_b} = ab;
        @(posedge clk); @(posedge clk);
        @(negedge clk); win_clr = 1'b1;
        @(negedge clk); win_clr = 1'b0;
        repeat (2) @(negedge clk);
        do_read(0);
        exp_freq = model_apply(exp_freq, 1, 0);
        chk("R6", "step in clear cycle", stat_cnt, 1);
        chk("R6", "dir of that step", stat_up, 0);
        chk("R6", "freq", freq_code, exp_freq);
    endtask

    task automatic t_clamp();
        clear_win();
        for (int i = 0; i < 4; i++) move(1);
        for (int i = 0; i < 40; i++) begin
            do_read(0);
            exp_freq = model_apply(exp_freq, 3, 1);
        end
        chk("R9", "upper edge", freq_code, 14600);
        chk("R9", "model upper", exp_freq, 14600);
        clear_win();
        for (int i = 0; i < 4; i++) move(0);
        for (int i = 0; i < 80; i++) begin
            do_read(0);
            exp_freq = model_apply(exp_freq, 3, 0);
        end
        chk("R9", "lower edge", freq_code, 14400);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_up_two();
        t_down_one();
        t_saturate();
        t_double_move();
        t_reverse();
        t_status_hold();
        t_reread();
        t_memory();
        t_read_clear();
        t_step_in_clear();
        t_clamp();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule